// File: doc/BRIEF.md
# Calendar Day and Month Counter

This block tracks the day of the month and the month of the year. It advances once per day on a single-cycle day strobe, and it honours the length of each month. A leap-year flag, which the user sets, gives February a 29th day. A month strobe is raised whenever the day count rolls over, so a following stage can react to the start of a new month.

The user sets the leap flag once during a leap year. The flag clears itself when December rolls over into January, so the next year counts as a common year with no further action. A synchronous master clear returns the block to the first day of January with the flag cleared. Year counting and display are handled outside this block.

Top module: `cal_day_month`

## Requirements
- R1: While `clr` is high at a rising edge, the next outputs are `mday` = 1, `month` = 1 and `month_tick` = 0, and the leap flag is cleared; `clr` takes priority over every other input.
- R2: A `day_tick` pulse on a day that is not the last day of its month raises `mday` by one in the cycle after the edge. With `day_tick` low, `mday` and `month` hold.
- R3: In months 1, 3, 5, 7, 8, 10 and 12, a `day_tick` on day 31 loads `mday` with 1 and advances the month.
- R4: In months 4, 6, 9 and 11, a `day_tick` on day 30 loads `mday` with 1 and advances the month.
- R5: In month 2, a `day_tick` wraps the day after day 28 when the leap flag is clear, and after day 29 when it is set. The flag value used is the one held before that edge.
- R6: `month_tick` is high for exactly one cycle, the cycle in which the wrapped `mday` = 1 and the new month first appear. `month` changes at no other time except clear.
- R7: A day wrap in month 12 loads `month` with 1.
- R8: A `leap_set` pulse sets the leap flag. The month-12 wrap clears the flag unless `leap_set` is high on the same edge, in which case `leap_set` wins.
- R9: `mday` always lies in 1..31 and `month` in 1..12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous master clear, active high |
| day_tick | input | 1 | One-cycle strobe, once per day |
| leap_set | input | 1 | Sets the leap-year flag |
| mday | output | DAY_W (5) | Day of month, 1-based |
| month | output | MON_W (4) | Month, 1 = January |
| month_tick | output | 1 | One-cycle strobe on month rollover |

## Verification
A wrong month length or a stale leap flag does not show at the ports straight away. It shows only at the next month end, when `mday` either passes the true last day or wraps too early. For that reason the bench walks complete years, so every month boundary is reached. A leap flag that fails to clear at year end appears only at the following February, about 59 day ticks later. A corrupted `month` shows at once as an out-of-range value or as a change without `month_tick`.

// File: rtl/cal_day_month.sv
module cal_day_month #(
  parameter int DAY_W = 5,
  parameter int MON_W = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             day_tick,
  input  logic             leap_set,
  output logic [DAY_W-1:0] mday,
  output logic [MON_W-1:0] month,
  output logic             month_tick
);
  localparam logic [DAY_W-1:0] FIRST_DAY = DAY_W'(1);
  localparam logic [MON_W-1:0] JAN = MON_W'(1);
  localparam logic [MON_W-1:0] DEC = MON_W'(12);

  logic             leap_q;
  logic [DAY_W-1:0] last_day;
  logic             day_end;
  logic             year_end;

  always_comb begin
    case (month)
      MON_W'(2):                       last_day = leap_q ? DAY_W'(29) : DAY_W'(28);
      MON_W'(4), MON_W'(6),
      MON_W'(9), MON_W'(11):           last_day = DAY_W'(30);
      default:                         last_day = DAY_W'(31);
    endcase
  end

  assign day_end  = day_tick && (mday == last_day);
  assign year_end = day_end && (month == DEC);

  always_ff @(posedge clk) begin
    if (clr) begin
      mday       <= FIRST_DAY;
      month      <= JAN;
      month_tick <= 1'b0;
      leap_q     <= 1'b0;
    end else begin
      month_tick <= day_end;
      if (day_tick)
        mday <= day_end ? FIRST_DAY : mday + FIRST_DAY;
      if (day_end)
        month <= year_end ? JAN : month + JAN;
      if (leap_set)
        leap_q <= 1'b1;
      else if (year_end)
        leap_q <= 1'b0;
    end
  end
endmodule

module cal_day_month_chk #(
  parameter int DAY_W = 5,
  parameter int MON_W = 4
) (
  input logic             clk,
  input logic             clr,
  input logic             day_tick,
  input logic [DAY_W-1:0] mday,
  input logic [MON_W-1:0] month,
  input logic             month_tick
);
  a_r9_range: assert property (@(posedge clk) disable iff (clr)
    (mday >= DAY_W'(1)) && (mday <= DAY_W'(31)) && (month >= MON_W'(1)) && (month <= MON_W'(12)));

  a_r1_clear: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (mday == DAY_W'(1)) && (month == MON_W'(1)) && !month_tick);

  a_r2_hold: assert property (@(posedge clk) disable iff (clr)
    !day_tick |=> $stable(mday) && $stable(month));

  a_r2_step: assert property (@(posedge clk) disable iff (clr)
    (day_tick && (mday < DAY_W'(28))) |=> (mday == $past(mday) + DAY_W'(1)));

  a_r6_tick_day_one: assert property (@(posedge clk) disable iff (clr)
    month_tick |-> (mday == DAY_W'(1)));

  a_r6_month_moves_with_tick: assert property (@(posedge clk) disable iff (clr)
    (!$stable(month) && !$past(clr)) |-> month_tick);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (clr)
    month_tick |=> !month_tick);
endmodule

bind cal_day_month cal_day_month_chk #(.DAY_W(DAY_W), .MON_W(MON_W)) u_chk (
  .clk(clk), .clr(clr), .day_tick(day_tick),
  .mday(mday), .month(month), .month_tick(month_tick)
);

// File: tb/tb_cal_day_month.sv
module tb_cal_day_month;
  localparam int CLK_P = 10;

  typedef struct {
    int    d;
    int    m;
    bit    mt;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       clr = 1'b1;
  logic       day_tick = 1'b0;
  logic       leap_set = 1'b0;
  logic [4:0] mday;
  logic [3:0] month;
  logic       month_tick;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t q[$];

  int e_d = 1, e_m = 1;
  bit e_lp = 1'b0, e_cleared = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cal_day_month dut (
    .clk(clk), .clr(clr), .day_tick(day_tick), .leap_set(leap_set),
    .mday(mday), .month(month), .month_tick(month_tick)
  );

  function automatic int mlen(int m, bit lp);
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic step(input bit t, input bit s, input bit c);
    exp_t it;
    @(negedge clk);
    day_tick = t; leap_set = s; clr = c;
    it.mt = 1'b0;
    if (c) begin
      e_d = 1; e_m = 1; e_lp = 1'b0; e_cleared = 1'b0;
      it.tag = "R1";
    end else begin
      it.tag = t ? "R2" : "R2 hold";
      if (t) begin
        if (e_d == mlen(e_m, e_lp)) begin
          it.mt = 1'b1;
          if (e_m == 2) it.tag = e_cleared ? "R8 R5 R6" : "R5 R6";
          else if (e_m == 12) it.tag = "R7 R3 R6";
          else if (mlen(e_m, 1'b0) == 30) it.tag = "R4 R6";
          else it.tag = "R3 R6";
          if (e_m == 12) begin
            e_m = 1; e_lp = 1'b0; e_cleared = 1'b1;
          end else e_m++;
          e_d = 1;
        end else e_d++;
      end
      if (s) begin
        e_lp = 1'b1;
        e_cleared = 1'b0;
      end
    end
    it.d = e_d; it.m = e_m;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        n_run++;
        if (mday !== 5'(it.d) || month !== 4'(it.m) || month_tick !== it.mt) begin
          n_fail++;
          $display("FAIL %s: got day=%0d month=%0d tick=%0b, expected day=%0d month=%0d tick=%0b",
                   it.tag, mday, month, month_tick, it.d, it.m, it.mt);
        end
        n_run++;
        if (!(mday >= 1 && mday <= 31 && month >= 1 && month <= 12)) begin
          n_fail++;
          $display("FAIL R9: got day=%0d month=%0d, expected day in 1..31 and month in 1..12",
                   mday, month);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: got no end, expected end of run");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0);
    // common year, idle cycles interleaved
    for (int i = 0; i < 365; i++) begin
      step(1, 0, 0);
      if (i % 7 == 0) step(0, 0, 0);
    end
    // leap year
    step(0, 1, 0);
    for (int i = 0; i < 366; i++) step(1, 0, 0);
    // flag cleared by year wrap: Feb wraps after 28 (R8)
    for (int i = 0; i < 59; i++) step(1, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 0, 0);
    // clear mid-year with a tick present (R1)
    step(1, 0, 1);
    step(0, 0, 0);
    // walk to Dec 31 and set the flag on the year-end edge (R8)
    for (int i = 0; i < 364; i++) step(1, 0, 0);
    step(1, 1, 0);
    for (int i = 0; i < 60; i++) step(1, 0, 0);
    // set the flag on the Feb 28 edge of a common year: old value applies (R5)
    step(1, 0, 1);
    for (int i = 0; i < 58; i++) step(1, 0, 0);
    step(1, 1, 0);
    step(1, 0, 0);
    step(0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule